// File: doc/BRIEF.md
# NAND Flash Bus Operation Engine

This block carries out one NAND flash bus operation each time the host writes an operation code into its trigger register. The operation is a command latch cycle, an address latch cycle, a transfer from the internal page buffer to the flash, a transfer from the flash into the page buffer, an identifier read or a status read. While it runs, the engine drives the chip enable, the command and address latch enables, the write and read strobes and the flash data bus. When it finishes it raises a sticky completion flag, which can also drive an interrupt line.

The host writes the command byte, the address byte, the buffer area number and the configuration through a small 16-bit register port. A separate word port lets it fill and drain the page buffer. The buffer has four main areas and four spare areas. A transfer goes through one main/spare pair, and the host picks the pair before it starts the transfer. The spare-only setting limits a transfer to the spare area. The flash bus can be 8 or 16 bits wide.

Top module: `nfe_engine`

## Requirements
- R1: After reset the flash is deselected (`nf_ce_n`=1), both strobes are high, `nf_cle`, `nf_ale` and `irq` are low, and every register reads as 0.
- R2: Writing trigger bit 0 performs a command cycle. `nf_cle` is high, the low byte of the command register is on `nf_io_out[7:0]`, and `nf_we_n` goes low for `T_LO` clocks and then high for `T_HI` clocks.
- R3: Writing trigger bit 1 performs the same cycle for the low byte of the address register with `nf_ale` high. `nf_cle` and `nf_ale` are never high at the same time.
- R4: Writing trigger bit 2 sends buffer contents to the flash with one `nf_we_n` strobe per unit. The stream is main area k (word offset k*256, 512 bytes) followed by spare area k (word offset 1024+k*8, 16 bytes), where k is the buffer-select register. On an 8-bit bus (config bit 0 = 0), each strobe carries one byte, and the low byte of each word goes first.
- R5: With config bit 0 = 1, the bus is 16 bits wide and each strobe moves one whole buffer word.
- R6: With config bit 2 = 1, a transfer moves only the 16 bytes of the selected spare area.
- R7: Writing trigger bit 3 fills the same byte stream from the flash, one `nf_re_n` strobe per unit, and leaves all other buffer words unchanged. No read strobe starts while `nf_rb_n` is low.
- R8: Writing trigger bit 4 reads `ID_UNITS` units into the selected main area, starting at offset 0. Units are packed like R7.
- R9: Writing trigger bit 5 reads one unit into the first word of the selected main area. On an 8-bit bus the upper byte of that word becomes 0.
- R10: Trigger bit 15 becomes 1 when an operation ends. It stays 1 until the host writes the trigger register with bit 15 = 0. While an operation runs, the trigger register reads back the running operation's bit.
- R11: `irq` is high while the completion flag is 1 and config bit 4 (interrupt mask) is 0.
- R12: `nf_ce_n` is low during an operation and, when config bit 7 is 1, also while idle. A strobe never falls while `nf_ce_n` is high.
- R13: A trigger write made while an operation is in progress is ignored.
- R14: Config bits 3 and 6 are stored and read back but do not change any bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 command, 1 address, 2 buffer select, 3 trigger, 4 config |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| buf_addr | input | BUF_AW (11) | Host word address into the page buffer |
| buf_we | input | 1 | Host buffer write enable |
| buf_wdata | input | 16 | Host buffer write data |
| buf_rdata | output | 16 | Host buffer read data (combinational) |
| irq | output | 1 | Completion interrupt |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 16 | Flash data bus, driven value |
| nf_io_oe | output | 1 | Flash data bus output enable |
| nf_io_in | input | 16 | Flash data bus, sampled value |
| nf_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
Both transfer directions are swept over every combination of bus width, spare-only setting and buffer area. Every strobe carries a value unique to its position, so the run can tell apart a wrong area, a wrong byte lane, a wrong order and a wrong stream length. After each inbound transfer the whole buffer is read back, which also shows any write that lands outside the selected area. An inbound transfer is started with ready/busy held low and a second trigger is written during the wait, which checks both the ready wait and that the second trigger is dropped. Identifier and status reads, mask changes, forced chip enable and stored-only config bits are each checked separately.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_LO, ST_HI} seq_st_e;

    localparam int OPS     = 6;
    localparam int OP_CMD  = 0;
    localparam int OP_ADR  = 1;
    localparam int OP_DIN  = 2;
    localparam int OP_DOUT = 3;
    localparam int OP_ID   = 4;
    localparam int OP_STAT = 5;

    localparam int RG_CMD  = 0;
    localparam int RG_ADR  = 1;
    localparam int RG_SEL  = 2;
    localparam int RG_TRIG = 3;
    localparam int RG_CFG  = 4;

    localparam int CF_WIDE  = 0;
    localparam int CF_SPARE = 2;
    localparam int CF_MASK  = 4;
    localparam int CF_FCE   = 7;
    localparam int FLAG_BIT = 15;
endpackage

// File: rtl/nfe_regs.sv
module nfe_regs
    import nfe_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic [OPS-1:0]   cur_op_i,
    output logic             start_o,
    output logic [OPS-1:0]   op_o,
    output logic [15:0]      cmd_o,
    output logic [15:0]      adr_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [15:0]      cfg_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [15:0]      cmd;
        logic [15:0]      adr;
        logic [15:0]      cfg;
        logic [SEL_W-1:0] sel;
        logic             flag;
    } regs_t;

    regs_t q, d;
    logic trig_wr;
    logic [OPS-1:0] req;

    always_comb begin
        d       = q;
        trig_wr = reg_wr && (reg_addr == 3'(RG_TRIG));
        req     = reg_wdata[OPS-1:0];
        op_o    = req & (~req + 1'b1);
        start_o = trig_wr && (|req) && !busy_i;
        if (reg_wr) begin
            case (int'(reg_addr))
                RG_CMD:  d.cmd = reg_wdata;
                RG_ADR:  d.adr = reg_wdata;
                RG_SEL:  d.sel = reg_wdata[SEL_W-1:0];
                RG_CFG:  d.cfg = reg_wdata;
                default: ;
            endcase
        end
        if (trig_wr && !reg_wdata[FLAG_BIT]) d.flag = 1'b0;
        if (done_i) d.flag = 1'b1;
        case (int'(reg_addr))
            RG_CMD:  reg_rdata = q.cmd;
            RG_ADR:  reg_rdata = q.adr;
            RG_SEL:  reg_rdata = 16'(q.sel);
            RG_TRIG: reg_rdata = {q.flag, 15'(cur_op_i)};
            RG_CFG:  reg_rdata = q.cfg;
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_o = q.cmd;
    assign adr_o = q.adr;
    assign sel_o = q.sel;
    assign cfg_o = q.cfg;
    assign irq_o = q.flag && !q.cfg[CF_MASK];

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !(trig_wr && !reg_wdata[FLAG_BIT])) |=> q.flag);

    p_irq_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !q.cfg[CF_MASK] && !(reg_wr && reg_addr == 3'(RG_CFG))) |=> irq_o);
endmodule

// File: rtl/nfe_pagebuf.sv
module nfe_pagebuf #(
    parameter int WORDS  = 1056,
    parameter int BUF_AW = 11
) (
    input  logic              clk,
    input  logic [BUF_AW-1:0] h_addr,
    input  logic              h_we,
    input  logic [15:0]       h_wdata,
    output logic [15:0]       h_rdata,
    input  logic [BUF_AW-1:0] e_addr,
    input  logic              e_we,
    input  logic [1:0]        e_be,
    input  logic [15:0]       e_wdata,
    output logic [15:0]       e_rdata
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (h_we) mem[h_addr] <= h_wdata;
        if (e_we) begin
            for (int ln = 0; ln < 2; ln++) begin
                if (e_be[ln]) mem[e_addr][ln*8 +: 8] <= e_wdata[ln*8 +: 8];
            end
        end
    end

    assign h_rdata = mem[h_addr];
    assign e_rdata = mem[e_addr];
endmodule

// File: rtl/nfe_seq.sv
module nfe_seq
    import nfe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int AREAS       = 4,
    parameter int T_LO        = 2,
    parameter int T_HI        = 1,
    parameter int ID_UNITS    = 6,
    parameter int SEL_W       = 2,
    parameter int BUF_AW      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OPS-1:0]    op_i,
    input  logic [15:0]       cmd_i,
    input  logic [15:0]       adr_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [15:0]       cfg_i,
    input  logic              rb_n_i,
    input  logic [15:0]       io_in_i,
    input  logic [15:0]       buf_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [OPS-1:0]    cur_op_o,
    output logic [BUF_AW-1:0] buf_addr_o,
    output logic              buf_we_o,
    output logic [1:0]        buf_be_o,
    output logic [15:0]       buf_wdata_o,
    output logic              ce_n_o,
    output logic              cle_o,
    output logic              ale_o,
    output logic              we_n_o,
    output logic              re_n_o,
    output logic [15:0]       io_out_o,
    output logic              io_oe_o
);
    localparam int MAIN_W     = MAIN_BYTES / 2;
    localparam int SPARE_W    = SPARE_BYTES / 2;
    localparam int SPARE_BASE = AREAS * MAIN_W;
    localparam int PW         = $clog2(MAIN_BYTES + SPARE_BYTES + 1);
    localparam int TMAX       = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int TW         = $clog2(TMAX + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [OPS-1:0]   op;
        logic             wide;
        logic             spare;
        logic [SEL_W-1:0] sel;
        logic [TW-1:0]    tcnt;
        logic [PW-1:0]    pos;
    } seq_t;

    seq_t q, d;
    logic [PW-1:0] units_m1;
    logic [PW:0]   boff;
    logic          is_rd, is_wr, is_xfer, lo_end, hi_end;
    int            bytes_n, word_i;

    always_comb begin
        d       = q;
        is_rd   = q.op[OP_DOUT] | q.op[OP_ID] | q.op[OP_STAT];
        is_wr   = q.op[OP_CMD] | q.op[OP_ADR] | q.op[OP_DIN];
        is_xfer = q.op[OP_DIN] | q.op[OP_DOUT];
        bytes_n = q.spare ? SPARE_BYTES : MAIN_BYTES + SPARE_BYTES;
        if (is_xfer)          units_m1 = PW'((q.wide ? bytes_n / 2 : bytes_n) - 1);
        else if (q.op[OP_ID]) units_m1 = PW'(ID_UNITS - 1);
        else                  units_m1 = '0;
        boff = q.wide ? {q.pos, 1'b0} : {1'b0, q.pos};
        if (is_xfer && (q.spare || int'(boff) >= MAIN_BYTES))
            word_i = SPARE_BASE + int'(q.sel) * SPARE_W
                   + ((q.spare ? int'(boff) : int'(boff) - MAIN_BYTES) >> 1);
        else
            word_i = int'(q.sel) * MAIN_W + (int'(boff) >> 1);
        lo_end = (q.tcnt == TW'(T_LO - 1));
        hi_end = (q.tcnt == TW'(T_HI - 1));
        done_o = (q.st == ST_HI) && hi_end && (q.pos == units_m1);

        case (q.st)
            ST_IDLE: if (start_i) begin
                d.op    = op_i;
                d.wide  = cfg_i[CF_WIDE];
                d.spare = cfg_i[CF_SPARE];
                d.sel   = sel_i;
                d.tcnt  = '0;
                d.pos   = '0;
                d.st    = op_i[OP_DOUT] ? ST_WAIT : ST_LO;
            end
            ST_WAIT: if (rb_n_i) d.st = ST_LO;
            ST_LO: begin
                d.tcnt = lo_end ? '0 : q.tcnt + 1'b1;
                if (lo_end) d.st = ST_HI;
            end
            default: begin
                d.tcnt = hi_end ? '0 : q.tcnt + 1'b1;
                if (hi_end) begin
                    if (q.pos == units_m1) d.st = ST_IDLE;
                    else begin
                        d.pos = q.pos + 1'b1;
                        d.st  = ST_LO;
                    end
                end
            end
        endcase

        busy_o      = (q.st != ST_IDLE);
        cur_op_o    = busy_o ? q.op : '0;
        buf_addr_o  = BUF_AW'(word_i);
        buf_we_o    = (q.st == ST_LO) && is_rd && lo_end;
        buf_be_o    = (q.wide || q.op[OP_STAT]) ? 2'b11 : (boff[0] ? 2'b10 : 2'b01);
        if (q.wide)              buf_wdata_o = io_in_i;
        else if (q.op[OP_STAT])  buf_wdata_o = {8'h00, io_in_i[7:0]};
        else                     buf_wdata_o = {io_in_i[7:0], io_in_i[7:0]};
        if (q.op[OP_CMD])        io_out_o = {8'h00, cmd_i[7:0]};
        else if (q.op[OP_ADR])   io_out_o = {8'h00, adr_i[7:0]};
        else if (q.wide)         io_out_o = buf_rdata_i;
        else                     io_out_o = {8'h00, boff[0] ? buf_rdata_i[15:8] : buf_rdata_i[7:0]};
        io_oe_o = busy_o && is_wr;
        cle_o   = busy_o && q.op[OP_CMD];
        ale_o   = busy_o && q.op[OP_ADR];
        we_n_o  = !((q.st == ST_LO) && is_wr);
        re_n_o  = !((q.st == ST_LO) && is_rd);
        ce_n_o  = !(busy_o || cfg_i[CF_FCE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    p_strobe_in_ce_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_o || !re_n_o) |-> !ce_n_o);

    p_wait_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && !rb_n_i) |=> re_n_o);

    p_no_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);
endmodule

// File: rtl/nfe_engine.sv
module nfe_engine
    import nfe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int AREAS       = 4,
    parameter int T_LO        = 2,
    parameter int T_HI        = 1,
    parameter int ID_UNITS    = 6,
    parameter int BUF_AW      = $clog2(AREAS * (MAIN_BYTES + SPARE_BYTES) / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [BUF_AW-1:0] buf_addr,
    input  logic              buf_we,
    input  logic [15:0]       buf_wdata,
    output logic [15:0]       buf_rdata,
    output logic              irq,
    output logic              nf_ce_n,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [15:0]       nf_io_out,
    output logic              nf_io_oe,
    input  logic [15:0]       nf_io_in,
    input  logic              nf_rb_n
);
    localparam int SEL_W = (AREAS > 1) ? $clog2(AREAS) : 1;
    localparam int WORDS = AREAS * (MAIN_BYTES + SPARE_BYTES) / 2;

    logic              busy, done, start;
    logic [OPS-1:0]    cur_op, op;
    logic [15:0]       cmd, adr, cfg, e_rdata, e_wdata;
    logic [SEL_W-1:0]  sel;
    logic [BUF_AW-1:0] e_addr;
    logic              e_we;
    logic [1:0]        e_be;

    nfe_regs #(.SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
        .done_i(done), .cur_op_i(cur_op), .start_o(start), .op_o(op),
        .cmd_o(cmd), .adr_o(adr), .sel_o(sel), .cfg_o(cfg), .irq_o(irq)
    );

    nfe_pagebuf #(.WORDS(WORDS), .BUF_AW(BUF_AW)) buf_i (
        .clk(clk), .h_addr(buf_addr), .h_we(buf_we), .h_wdata(buf_wdata),
        .h_rdata(buf_rdata), .e_addr(e_addr), .e_we(e_we), .e_be(e_be),
        .e_wdata(e_wdata), .e_rdata(e_rdata)
    );

    nfe_seq #(
        .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .AREAS(AREAS),
        .T_LO(T_LO), .T_HI(T_HI), .ID_UNITS(ID_UNITS), .SEL_W(SEL_W), .BUF_AW(BUF_AW)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .cmd_i(cmd),
        .adr_i(adr), .sel_i(sel), .cfg_i(cfg), .rb_n_i(nf_rb_n), .io_in_i(nf_io_in),
        .buf_rdata_i(e_rdata), .busy_o(busy), .done_o(done), .cur_op_o(cur_op),
        .buf_addr_o(e_addr), .buf_we_o(e_we), .buf_be_o(e_be), .buf_wdata_o(e_wdata),
        .ce_n_o(nf_ce_n), .cle_o(nf_cle), .ale_o(nf_ale), .we_n_o(nf_we_n),
        .re_n_o(nf_re_n), .io_out_o(nf_io_out), .io_oe_o(nf_io_oe)
    );
endmodule

// File: tb/nfe_engine_tb.sv
module nfe_engine_tb_top;
    localparam int MB = 512, SB = 16, AR = 4, TLO = 2, THI = 1, IDU = 6;
    localparam int MW = MB / 2, SW = SB / 2, SBASE = AR * MW, WORDS = SBASE + AR * SW, AW = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, buf_we = 1'b0, nf_rb_n = 1'b1;
    logic [2:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0, buf_wdata = '0, nf_io_in = '0;
    logic [AW-1:0] buf_addr = '0;
    logic [15:0] reg_rdata, buf_rdata, nf_io_out;
    logic irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;

    always #5 clk = ~clk;

    nfe_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_addr(buf_addr),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .irq(irq),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
        .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
    );

    int checks = 0, errors = 0;
    int we_cnt = 0, re_cnt = 0, we_low = 0, last_w = 0, rb_viol = 0, ce_viol = 0;
    logic [15:0] cap_io [1024];
    logic cap_cle [1024];
    logic cap_ale [1024];
    logic [15:0] exp_mem [WORDS];
    logic pwe = 1'b1, pre = 1'b1;

    function automatic logic [15:0] pat(int n);
        return 16'(n * 40503 + 16'h1357);
    endfunction

    function automatic logic [15:0] minit(int w);
        return 16'(w * 16'h9E37) ^ 16'h5A5A;
    endfunction

    function automatic int waddr(int area, bit xfer, bit spare, int b);
        if (xfer && (spare || b >= MB))
            return SBASE + area * SW + ((spare ? b : b - MB) >> 1);
        return area * MW + (b >> 1);
    endfunction

    // flash model: capture write strobes, serve read strobes
    always @(negedge clk) begin
        if (!nf_we_n) we_low++;
        if (!pwe && nf_we_n) begin
            if (we_cnt < 1024) begin
                cap_io[we_cnt]  = nf_io_out;
                cap_cle[we_cnt] = nf_cle;
                cap_ale[we_cnt] = nf_ale;
            end
            we_cnt++;
            last_w = we_low;
            we_low = 0;
        end
        if (pre && !nf_re_n) begin
            nf_io_in = pat(re_cnt);
            re_cnt++;
            if (!nf_rb_n) rb_viol++;
        end
        if ((!nf_we_n || !nf_re_n) && nf_ce_n) ce_viol++;
        pwe = nf_we_n;
        pre = nf_re_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wreg(input int a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input int a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [15:0] v;
        v = '0;
        for (int i = 0; i < 20000; i++) begin
            rreg(3, v);
            if (v[15]) break;
        end
        if (!v[15]) check(1'b0, req, 0, 1);
    endtask

    task automatic mem_compare(input string req);
        int bad, first;
        logic [15:0] v;
        bad = 0; first = -1;
        for (int w = 0; w < WORDS; w++) begin
            @(negedge clk);
            buf_addr = AW'(w);
            #1 v = buf_rdata;
            if (v !== exp_mem[w]) begin
                bad++;
                if (first < 0) first = w;
            end
        end
        check(bad == 0, req, bad, 0);
        if (bad != 0) $display("  first mismatching word %0d", first);
    endtask

    task automatic read_op(input int trig, input bit wide, input bit spare, input int area,
                           input int units, input bit xfer, input bit stat, input string req);
        wreg(4, 16'({spare, 1'b0, wide}));
        wreg(2, 16'(area));
        re_cnt = 0;
        wreg(3, 16'(trig));
        wait_done(req);
        for (int i = 0; i < units; i++) begin
            int b, w;
            logic [15:0] v;
            b = wide ? 2 * i : i;
            w = waddr(area, xfer, spare, b);
            v = pat(i);
            if (wide) exp_mem[w] = v;
            else if (stat) exp_mem[w] = {8'h00, v[7:0]};
            else if (b % 2 == 1) exp_mem[w][15:8] = v[7:0];
            else exp_mem[w][7:0] = v[7:0];
        end
        check(re_cnt == units, req, re_cnt, units);
        mem_compare(req);
        wreg(3, 16'h0000);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !irq, "R1",
              {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, 6'b111000);
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) begin
            rreg(a, v);
            check(v == 16'h0, "R1", v, 0);
        end

        // R2: command cycle
        wreg(0, 16'h1290);
        we_cnt = 0;
        wreg(3, 16'h0001);
        wait_done("R2");
        check(we_cnt == 1 && cap_cle[0] && !cap_ale[0] && cap_io[0][7:0] == 8'h90 && last_w == TLO,
              "R2", {cap_cle[0], cap_ale[0], cap_io[0][7:0]}, {2'b10, 8'h90});
        // R11: interrupt with mask clear, then masked
        check(irq == 1'b1, "R11", irq, 1);
        repeat (5) @(negedge clk);
        rreg(3, v);
        check(v == 16'h8000, "R10", v, 16'h8000);
        wreg(3, 16'h8000);
        rreg(3, v);
        check(v == 16'h8000, "R10", v, 16'h8000);
        wreg(4, 16'h0010);
        check(irq == 1'b0, "R11", irq, 0);
        wreg(4, 16'h0000);
        check(irq == 1'b1, "R11", irq, 1);
        wreg(3, 16'h0000);
        rreg(3, v);
        check(v == 16'h0 && !irq, "R10", v, 0);

        // R3: address cycle
        wreg(1, 16'hA53C);
        we_cnt = 0;
        wreg(3, 16'h0002);
        wait_done("R3");
        check(we_cnt == 1 && !cap_cle[0] && cap_ale[0] && cap_io[0][7:0] == 8'h3C && last_w == TLO,
              "R3", {cap_cle[0], cap_ale[0], cap_io[0][7:0]}, {2'b01, 8'h3C});
        wreg(3, 16'h0000);

        // R12: forced chip enable while idle
        wreg(4, 16'h0080);
        check(nf_ce_n == 1'b0, "R12", nf_ce_n, 0);
        wreg(4, 16'h0000);
        check(nf_ce_n == 1'b1, "R12", nf_ce_n, 1);

        // R14: stored-only config bits
        wreg(4, 16'h0048);
        rreg(4, v);
        check(v == 16'h0048, "R14", v, 16'h48);
        we_cnt = 0;
        wreg(3, 16'h0001);
        wait_done("R14");
        check(we_cnt == 1 && cap_cle[0] && cap_io[0] == 16'h0090 && last_w == TLO,
              "R14", cap_io[0], 16'h0090);
        wreg(3, 16'h0000);
        wreg(4, 16'h0000);

        // preload the buffer
        for (int w = 0; w < WORDS; w++) begin
            @(negedge clk);
            buf_addr = AW'(w); buf_wdata = minit(w); buf_we = 1'b1;
            exp_mem[w] = minit(w);
        end
        @(negedge clk);
        buf_we = 1'b0;

        // R4 R5 R6: buffer to flash sweep
        for (int wide = 0; wide < 2; wide++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int area = 0; area < AR; area++) begin
                    int units, bad;
                    string req;
                    req = (wide != 0) ? "R5" : ((sp != 0) ? "R6" : "R4");
                    units = (sp != 0) ? SB : MB + SB;
                    if (wide != 0) units = units / 2;
                    wreg(4, 16'((sp << 2) | wide));
                    wreg(2, 16'(area));
                    we_cnt = 0;
                    wreg(3, 16'h0004);
                    wait_done(req);
                    bad = 0;
                    for (int i = 0; i < units; i++) begin
                        int b;
                        logic [15:0] e;
                        b = (wide != 0) ? 2 * i : i;
                        e = exp_mem[waddr(area, 1'b1, sp != 0, b)];
                        if (wide == 0) e = (b % 2 == 1) ? {8'h00, e[15:8]} : {8'h00, e[7:0]};
                        if (cap_io[i] !== e || cap_cle[i] || cap_ale[i]) bad++;
                    end
                    check(we_cnt == units && bad == 0, req, we_cnt * 1000 + bad, units * 1000);
                    wreg(3, 16'h0000);
                end
            end
        end

        // R7: flash to buffer sweep; first run also covers R13
        for (int wide = 0; wide < 2; wide++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int area = 0; area < AR; area++) begin
                    int units, bad;
                    units = (sp != 0) ? SB : MB + SB;
                    if (wide != 0) units = units / 2;
                    wreg(4, 16'((sp << 2) | wide));
                    wreg(2, 16'(area));
                    re_cnt = 0; we_cnt = 0;
                    nf_rb_n = 1'b0;
                    wreg(3, 16'h0008);
                    if (wide == 0 && sp == 0 && area == 0) begin
                        wreg(3, 16'h0001);
                        rreg(3, v);
                        check(v[5:0] == 6'b001000, "R13", v, 16'h0008);
                    end
                    repeat (10) @(negedge clk);
                    check(re_cnt == 0 && nf_re_n, "R7", re_cnt, 0);
                    nf_rb_n = 1'b1;
                    wait_done("R7");
                    if (wide == 0 && sp == 0 && area == 0)
                        check(we_cnt == 0, "R13", we_cnt, 0);
                    for (int i = 0; i < units; i++) begin
                        int b, w;
                        logic [15:0] p;
                        b = (wide != 0) ? 2 * i : i;
                        w = waddr(area, 1'b1, sp != 0, b);
                        p = pat(i);
                        if (wide != 0) exp_mem[w] = p;
                        else if (b % 2 == 1) exp_mem[w][15:8] = p[7:0];
                        else exp_mem[w][7:0] = p[7:0];
                    end
                    bad = (re_cnt == units) ? 0 : 1;
                    check(bad == 0 && rb_viol == 0, "R7", re_cnt, units);
                    mem_compare("R7");
                    wreg(3, 16'h0000);
                end
            end
        end

        // R8: identifier read, both bus widths
        read_op(16'h0010, 1'b0, 1'b0, 2, IDU, 1'b0, 1'b0, "R8");
        read_op(16'h0010, 1'b1, 1'b0, 1, IDU, 1'b0, 1'b0, "R8");
        // R9: status read, both bus widths
        read_op(16'h0020, 1'b0, 1'b0, 1, 1, 1'b0, 1'b1, "R9");
        read_op(16'h0020, 1'b1, 1'b0, 3, 1, 1'b0, 1'b1, "R9");

        // R12: no strobe fell outside chip enable
        check(ce_viol == 0, "R12", ce_viol, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule